// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words are 9 bits wide. The depth is a power-of-two parameter. Each side owns a binary pointer and a Gray-coded copy of it. Only the Gray copy crosses into the other domain, through a two-stage synchronizer. Four active-low flags report the fill state: empty (read clock), full (write clock), almost-empty (read clock) and almost-full (write clock). The two "almost" thresholds are set by two offset registers.

A dual-purpose write pin is captured while reset is held, and it sets the mode for the whole session. If it is captured high, the pin acts as a second, active-high write enable. If it is captured low, the pin becomes a load strobe. Holding the strobe low while the main write enable is low writes the next offset register instead of pushing data. Holding the strobe low while both read enables are low reads the next offset register instead of popping. Offset accesses alternate between the two registers, starting with the almost-empty offset after every reset. An active-low output enable either drives the registered read word or zeroes it, and a drive indication reports which.

Top module: `dcfifo_pf`

## Requirements
- R1: While and after reset, and before any write: `empty_n`=0, `full_n`=1, `almost_empty_n`=0 and `almost_full_n`=1. With `out_en_n` low, `rd_data` is 0.
- R2: In dual-enable mode, a rising `wr_clk` stores `wr_data` only when `wr_en1_n`=0, `wr_en2_ld`=1 and the FIFO is not full. With `wr_en2_ld`=0 the write is ignored.
- R3: A rising `rd_clk` pops the oldest word into `rd_data` only when `rd_en1_n`=0, `rd_en2_n`=0 and the FIFO is not empty. Words leave in write order. A read while empty leaves `rd_data` and the pointer unchanged.
- R4: `full_n` is 0 when DEPTH words are held. A write attempted while full is discarded.
- R5: `empty_n` is 0 when no word is held. It rises within a few read clocks after a write, because pointers cross domains as single-bit-change Gray code.
- R6: `almost_empty_n` is 0 when the fill level is at or below the almost-empty offset.
- R7: `almost_full_n` is 0 when the free space is at or below the almost-full offset.
- R8: The value of `wr_en2_ld` during reset picks the mode. 1 selects dual-enable mode and 0 selects load mode.
- R9: In load mode, a rising `wr_clk` with `wr_en1_n`=0 and `wr_en2_ld`=0 writes the low bits of `wr_data` into the next offset register, almost-empty first and then almost-full, alternating. The FIFO contents are not touched.
- R10: In load mode, a rising `rd_clk` with both read enables low and `wr_en2_ld`=0 places the next offset register (almost-empty first, alternating) on `rd_data` without popping. Both offsets are 7 after reset.
- R11: With `out_en_n`=1, `rd_data_drive` is 0 and `rd_data` is 0. With `out_en_n`=0, `rd_data_drive` is 1.
- R12: In load mode with `wr_en2_ld`=1, `wr_en1_n`=0 alone pushes data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en1_n | input | 1 | Main write enable, active low |
| wr_en2_ld | input | 1 | Second write enable or offset load strobe, picked at reset |
| wr_data | input | DW | Write word or offset value |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | DW | Registered read word or offset, zero when not driven |
| rd_data_drive | output | 1 | High when `rd_data` is driven |
| empty_n | output | 1 | Empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read clock |
| almost_full_n | output | 1 | Almost-full flag, active low, write clock |

## Verification
The bench builds the block with DEPTH 16 and keeps the data width at 9. With 16 entries, the full boundary, a rejected overfill and the default threshold of 7 on both sides can be reached in a couple of dozen writes. The 4-bit offsets also allow thresholds such as 3 and 12, so both almost flags can be seen toggling on opposite sides of a single write. The write clock and read clock have unrelated periods, so every flag check is taken after the Gray pointers have passed through the synchronizers.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;
    typedef enum logic {
        MODE_LOAD = 1'b0,
        MODE_DUAL = 1'b1
    } fifo_mode_e;

    localparam int DEF_DW    = 9;
    localparam int DEF_DEPTH = 256;
    localparam int DEF_OFF   = 7;
endpackage

// File: rtl/fifo_gray_sync.sv
module fifo_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH   = 256,
    parameter int AW      = 8,
    parameter int PW      = 9,
    parameter int DEF_OFF = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en1_n,
    input  logic          wr_en2_ld,
    input  logic [AW-1:0] off_in,
    input  logic [PW-1:0] rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output logic          full_n,
    output logic          almost_full_n
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
        logic          sel;
    } wr_st_t;

    wr_st_t     st_d, st_q;
    fifo_mode_e mode_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] level;
    logic [PW-1:0] free;
    logic          is_full;
    logic          push;
    logic          load;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= fifo_mode_e'(wr_en2_ld);
    end

    always_comb begin
        rbin[PW-1] = rgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) rbin[i] = rbin[i+1] ^ rgray_sync[i];
    end

    always_comb begin
        level   = st_q.ptr - rbin;
        free    = PW'(DEPTH) - level;
        is_full = (level == PW'(DEPTH));
        push    = !wr_en1_n && wr_en2_ld && !is_full;
        load    = (mode_q == MODE_LOAD) && !wr_en1_n && !wr_en2_ld;

        st_d = st_q;
        if (push) begin
            st_d.ptr  = st_q.ptr + 1'b1;
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (load) begin
            if (st_q.sel) st_d.af = off_in;
            else          st_d.ae = off_in;
            st_d.sel = !st_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ptr: '0, gray: '0, ae: AW'(DEF_OFF), af: AW'(DEF_OFF), sel: 1'b0};
        else        st_q <= st_d;
    end

    assign mem_we        = push;
    assign mem_addr      = st_q.ptr[AW-1:0];
    assign wgray         = st_q.gray;
    assign ae_off        = st_q.ae;
    assign af_off        = st_q.af;
    assign full_n        = !is_full;
    assign almost_full_n = !(free <= PW'(st_q.af));
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 8,
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en2_ld,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic [PW-1:0] wgray_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] data_out,
    output logic          empty_n,
    output logic          almost_empty_n
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [DW-1:0] data;
        logic          sel;
    } rd_st_t;

    rd_st_t     st_d, st_q;
    fifo_mode_e mode_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] level;
    logic          is_empty;
    logic          rd_req;
    logic          peek;
    logic          pop;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= fifo_mode_e'(wr_en2_ld);
    end

    always_comb begin
        wbin[PW-1] = wgray_sync[PW-1];
        for (int i = PW - 2; i >= 0; i--) wbin[i] = wbin[i+1] ^ wgray_sync[i];
    end

    always_comb begin
        level    = wbin - st_q.ptr;
        is_empty = (level == '0);
        rd_req   = !rd_en1_n && !rd_en2_n;
        peek     = rd_req && (mode_q == MODE_LOAD) && !wr_en2_ld;
        pop      = rd_req && !peek && !is_empty;

        st_d = st_q;
        if (pop) begin
            st_d.data = mem_rdata;
            st_d.ptr  = st_q.ptr + 1'b1;
            st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);
        end
        if (peek) begin
            st_d.data = st_q.sel ? DW'(af_off) : DW'(ae_off);
            st_d.sel  = !st_q.sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ptr: '0, gray: '0, data: '0, sel: 1'b0};
        else        st_q <= st_d;
    end

    assign mem_raddr      = st_q.ptr[AW-1:0];
    assign rgray          = st_q.gray;
    assign data_out       = st_q.data;
    assign empty_n        = !is_empty;
    assign almost_empty_n = !(level <= PW'(ae_off));
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf
    import fifo_pf_pkg::*;
#(
    parameter int DW      = DEF_DW,
    parameter int DEPTH   = DEF_DEPTH,
    parameter int OFF_RST = DEF_OFF
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en1_n,
    input  logic          wr_en2_ld,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic          out_en_n,
    output logic [DW-1:0] rd_data,
    output logic          rd_data_drive,
    output logic          empty_n,
    output logic          full_n,
    output logic          almost_empty_n,
    output logic          almost_full_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic          mem_we;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;
    logic [AW-1:0] ae_off, af_off;
    logic [DW-1:0] data_q;

    fifo_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .DEF_OFF(OFF_RST)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
        .off_in(AW'(wr_data)), .rgray_sync(rgray_ws), .mem_we(mem_we),
        .mem_addr(waddr), .wgray(wgray), .ae_off(ae_off), .af_off(af_off),
        .full_n(full_n), .almost_full_n(almost_full_n)
    );

    fifo_rd_ctl #(.DW(DW), .AW(AW), .PW(PW)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .wr_en2_ld(wr_en2_ld), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .wgray_sync(wgray_rs), .ae_off(ae_off), .af_off(af_off),
        .mem_rdata(mem[raddr]), .mem_raddr(raddr), .rgray(rgray), .data_out(data_q),
        .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    fifo_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_rs));
    fifo_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_ws));

    always_ff @(posedge wr_clk) begin
        if (mem_we) mem[waddr] <= wr_data;
    end

    assign rd_data_drive = !out_en_n;
    assign rd_data       = out_en_n ? '0 : data_q;
endmodule

// File: rtl/dcfifo_pf_chk.sv
module dcfifo_pf_chk #(
    parameter int DW = 9,
    parameter int PW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en2_ld,
    input logic          out_en_n,
    input logic [DW-1:0] rd_data,
    input logic          rd_data_drive,
    input logic          empty_n,
    input logic          full_n,
    input logic          almost_empty_n,
    input logic          almost_full_n,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);
    // R4
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |=> $stable(wgray));

    // R3
    no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |=> $stable(rgray));

    // R2 R9
    strobe_low_no_push_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !wr_en2_ld |=> $stable(wgray));

    // R6
    empty_is_almost_empty_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !empty_n |-> !almost_empty_n);

    // R7
    full_is_almost_full_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !full_n |-> !almost_full_n);

    // R5
    wgray_single_step_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R11
    undriven_zero_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
        out_en_n |-> (!rd_data_drive && rd_data == '0));
endmodule

bind dcfifo_pf dcfifo_pf_chk #(.DW(DW), .PW(PW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en2_ld(wr_en2_ld),
    .out_en_n(out_en_n), .rd_data(rd_data), .rd_data_drive(rd_data_drive),
    .empty_n(empty_n), .full_n(full_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .wgray(wgray), .rgray(rgray)
);

// File: tb/tb_dcfifo_pf.sv
module tb_dcfifo_pf;
    localparam int DW    = 9;
    localparam int DEPTH = 16;

    logic wr_clk = 0, rd_clk = 0, rst_n = 0;
    logic wr_en1_n = 1, wr_en2_ld = 1, rd_en1_n = 1, rd_en2_n = 1, out_en_n = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic rd_data_drive, empty_n, full_n, almost_empty_n, almost_full_n;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4   wr_clk = ~wr_clk;
    always #5.5 rd_clk = ~rd_clk;

    dcfifo_pf #(.DW(DW), .DEPTH(DEPTH)) dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
        .wr_en2_ld(wr_en2_ld), .wr_data(wr_data), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .out_en_n(out_en_n), .rd_data(rd_data),
        .rd_data_drive(rd_data_drive), .empty_n(empty_n), .full_n(full_n),
        .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rd_clk);
        repeat (8) @(negedge wr_clk);
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 0; wr_en2_ld = mode; wr_en1_n = 1; rd_en1_n = 1; rd_en2_n = 1;
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
        rst_n = 1;
        @(negedge wr_clk);
        wr_en2_ld = 1;
        settle();
    endtask

    task automatic wr_word(input logic en2, input logic [DW-1:0] v);
        @(negedge wr_clk);
        wr_en1_n = 0; wr_en2_ld = en2; wr_data = v;
        @(negedge wr_clk);
        wr_en1_n = 1; wr_en2_ld = 1;
    endtask

    task automatic rd_word(output logic [DW-1:0] v);
        @(negedge rd_clk);
        rd_en1_n = 0; rd_en2_n = 0;
        @(negedge rd_clk);
        rd_en1_n = 1; rd_en2_n = 1;
        v = rd_data;
    endtask

    function automatic logic [DW-1:0] pat(input int i);
        return DW'(i * 37 + 5);
    endfunction

    task automatic t_reset_state();
        do_reset(1'b1);
        check("R1 empty_n", DW'(empty_n), 1'b0);
        check("R1 full_n", DW'(full_n), 1'b1);
        check("R1 almost_empty_n", DW'(almost_empty_n), 1'b0);
        check("R1 almost_full_n", DW'(almost_full_n), 1'b1);
        check("R1 rd_data", rd_data, '0);
    endtask

    task automatic t_dual_fill_drain();
        logic [DW-1:0] v;
        wr_word(1'b0, 9'h0AA);
        settle();
        check("R2 en2 low ignored", DW'(empty_n), 1'b0);
        for (int i = 0; i < DEPTH; i++) begin
            wr_word(1'b1, pat(i));
            if (i == 6 || i == 7 || i == 8) begin
                settle();
                check("R6 almost_empty_n", DW'(almost_empty_n), (i >= 7) ? 1'b1 : 1'b0);
                check("R7 almost_full_n", DW'(almost_full_n), (i >= 8) ? 1'b0 : 1'b1);
            end
        end
        settle();
        check("R4 full_n at depth", DW'(full_n), 1'b0);
        check("R5 empty_n after writes", DW'(empty_n), 1'b1);
        check("R8 dual mode writes", DW'(empty_n), 1'b1);
        wr_word(1'b1, 9'h1FF);
        settle();
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(v);
            check("R3 order", v, pat(i));
        end
        settle();
        check("R5 empty_n after drain", DW'(empty_n), 1'b0);
        check("R4 full_n after drain", DW'(full_n), 1'b1);
        rd_word(v);
        check("R3 read while empty", v, pat(DEPTH - 1));
        wr_word(1'b1, 9'h155);
        settle();
        rd_word(v);
        check("R4 overfill discarded", v, 9'h155);
    endtask

    task automatic t_output_enable();
        @(negedge rd_clk);
        out_en_n = 1;
        @(negedge rd_clk);
        check("R11 rd_data undriven", rd_data, '0);
        check("R11 drive low", DW'(rd_data_drive), 1'b0);
        out_en_n = 0;
        @(negedge rd_clk);
        check("R11 drive high", DW'(rd_data_drive), 1'b1);
        check("R11 data back", rd_data, 9'h155);
    endtask

    task automatic t_load_mode();
        logic [DW-1:0] v;
        do_reset(1'b0);
        @(negedge wr_clk);
        wr_en2_ld = 0;
        rd_word(v); check("R10 default ae", v, 9'd7);
        rd_word(v); check("R10 default af", v, 9'd7);
        @(negedge wr_clk); wr_en1_n = 0; wr_data = 9'd3;
        @(negedge wr_clk); wr_data = 9'd12;
        @(negedge wr_clk); wr_en1_n = 1;
        settle();
        check("R9 no push", DW'(empty_n), 1'b0);
        check("R8 load mode", DW'(empty_n), 1'b0);
        rd_word(v); check("R9 ae loaded", v, 9'd3);
        rd_word(v); check("R10 af readback", v, 9'd12);
        settle();
        check("R10 no pop", DW'(empty_n), 1'b0);
        @(negedge wr_clk);
        wr_en2_ld = 1;
        for (int i = 0; i < 3; i++) wr_word(1'b1, pat(i + 40));
        settle();
        check("R12 push", DW'(empty_n), 1'b1);
        check("R6 level3 ae3", DW'(almost_empty_n), 1'b0);
        check("R7 free13 af12", DW'(almost_full_n), 1'b1);
        wr_word(1'b1, pat(43));
        settle();
        check("R6 level4 ae3", DW'(almost_empty_n), 1'b1);
        check("R7 free12 af12", DW'(almost_full_n), 1'b0);
        for (int i = 0; i < 4; i++) begin
            rd_word(v);
            check("R12 data order", v, pat(i + 40));
        end
    endtask

    initial begin
        t_reset_state();
        t_dual_fill_drain();
        t_output_enable();
        t_load_mode();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule